// File: doc/BRIEF.md
# Three-Writer Memory with Undefined-Collision Resolution

This block is a small synchronous word memory with three write ports and one read port. When two or more write ports are enabled in the same cycle and target the same word, the word is treated as undefined. Instead of letting one port's data win by priority, the block stores a pseudo-random word there. The three writers are ranked first, second and third. Exactly one port performs the randomized write: the earliest-ranked port that takes part in the collision. Every later-ranked port that collides with an earlier one is suppressed.

Each port that can be the earliest in a collision owns its own pseudo-random generator. These are the first- and second-ranked ports. A generator steps only in cycles in which its port's collision condition is true.

A parameter marks port pairs that the surrounding logic never enables together. For those pairs no collision term is built. They then never affect each other's data or enable.

Writes land one clock edge after they are presented. Reads are combinational from the read address.

Top module: `mwm_resolver`

## Requirements
- R1: At reset (active-low `rst_n`), the first port's generator loads `SEED_A` and the second port's generator loads `SEED_B`; both seeds are nonzero. Memory contents are not reset.
- R2: A port enabled with no collision stores its data at its address on the next rising clock edge.
- R3: Two ports collide only when both are enabled and their addresses are equal. Enabled ports on distinct addresses, or a single enabled port sharing an address with a disabled one, all write their own data.
- R4: When the first and second ports collide, the first port writes its generator's current word and the second port is suppressed.
- R5: When the first and third ports collide, the first port writes its generator's current word and the third port is suppressed.
- R6: When the second and third ports collide, the second port writes its generator's current word (unless the second port is itself suppressed by R4) and the third port is suppressed.
- R7: When all three ports collide, the stored word is the first port's generator word. The second port's generator still steps, because its own collision with the third port is true.
- R8: A generator's word is used in a collision cycle and the generator then steps once. It holds in every other cycle. One step is a right shift of the 32-bit state with the old bit 0 folded back: next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0).
- R9: Parameter `EXCL` bit 0 marks the first/second pair as exclusive, bit 1 the first/third pair, and bit 2 the second/third pair. A marked pair gets no collision term: it changes neither data nor enables, and it steps no generator. If a marked pair still writes one word, the later-ranked port's data remains.
- R10: `rd_data` shows the word at `rd_addr` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the generators |
| wa_en | input | 1 | First-ranked write enable |
| wa_addr | input | 5 | First-ranked write address |
| wa_data | input | 32 | First-ranked write data |
| wb_en | input | 1 | Second-ranked write enable |
| wb_addr | input | 5 | Second-ranked write address |
| wb_data | input | 32 | Second-ranked write data |
| wc_en | input | 1 | Third-ranked write enable |
| wc_addr | input | 5 | Third-ranked write address |
| wc_data | input | 32 | Third-ranked write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, combinational |

## Verification
Directed patterns come first: single writers, all three on distinct addresses, and an enabled port sharing an address with a disabled one. These separate true collisions from look-alikes. Each collision pair and the triple collision are then driven on their own, which tells apart the generator word that wins from the ports that are suppressed. The first collision after reset, and a collision after idle cycles, show whether a generator stepped when it should have held. A second instance with the first/third pair marked exclusive gets the same stimulus, plus a random stream on four addresses. Together these expose a missing or spurious collision term.

// File: rtl/mwm_pkg.sv
`timescale 1ns/1ps
package mwm_pkg;
    localparam int NPORTS = 3;
    localparam int NRAND  = 2;
    typedef enum int {PORT_A = 0, PORT_B = 1, PORT_C = 2} port_e;
    localparam logic [31:0] LFSR_TAPS = 32'h80200003;
endpackage

// File: rtl/mwm_lfsr.sv
`timescale 1ns/1ps
module mwm_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = 1,
    parameter logic [W-1:0] TAPS = 32'h80200003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] word
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    always_comb begin
        state_d = {1'b0, state_q[W-1:1]};
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_d;
        end
    end

    assign word = state_q;
endmodule

// File: rtl/mwm_collide.sv
`timescale 1ns/1ps
module mwm_collide #(
    parameter int         AW   = 5,
    parameter logic [2:0] EXCL = 3'b000
) (
    input  logic [2:0]    en,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [AW-1:0] addr_c,
    output logic          hit_ab,
    output logic          hit_ac,
    output logic          hit_bc,
    output logic          act_a,
    output logic          act_b,
    output logic [2:0]    we
);
    generate
        if (EXCL[0]) begin : g_ab_off
            assign hit_ab = 1'b0;
        end else begin : g_ab_on
            assign hit_ab = en[0] && en[1] && (addr_a == addr_b);
        end
        if (EXCL[1]) begin : g_ac_off
            assign hit_ac = 1'b0;
        end else begin : g_ac_on
            assign hit_ac = en[0] && en[2] && (addr_a == addr_c);
        end
        if (EXCL[2]) begin : g_bc_off
            assign hit_bc = 1'b0;
        end else begin : g_bc_on
            assign hit_bc = en[1] && en[2] && (addr_b == addr_c);
        end
    endgenerate

    assign act_a = hit_ab || hit_ac;
    assign act_b = hit_bc;

    assign we[0] = en[0];
    assign we[1] = en[1] && !hit_ab;
    assign we[2] = en[2] && !(hit_ac || hit_bc);
endmodule

// File: rtl/mwm_store.sv
`timescale 1ns/1ps
module mwm_store #(
    parameter int DEPTH  = 32,
    parameter int DW     = 32,
    parameter int NPORTS = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic [NPORTS-1:0]            we,
    input  logic [NPORTS-1:0][AW-1:0]    waddr,
    input  logic [NPORTS-1:0][DW-1:0]    wdata,
    input  logic [AW-1:0]                raddr,
    output logic [DW-1:0]                rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (we[p]) begin
                mem[waddr[p]] <= wdata[p];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mwm_resolver.sv
`timescale 1ns/1ps
module mwm_resolver
    import mwm_pkg::*;
#(
    parameter int          DEPTH  = 32,
    parameter int          DW     = 32,
    parameter logic [2:0]  EXCL   = 3'b000,
    parameter logic [31:0] SEED_A = 32'hACE1_2468,
    parameter logic [31:0] SEED_B = 32'h1357_BDF1,
    localparam int         AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic          wc_en,
    input  logic [AW-1:0] wc_addr,
    input  logic [DW-1:0] wc_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic                      hit_ab, hit_ac, hit_bc;
    logic [NRAND-1:0]          rnd_step;
    logic [NRAND-1:0][DW-1:0]  rnd_word;
    logic [NPORTS-1:0]         port_we;
    logic [NPORTS-1:0][AW-1:0] port_addr;
    logic [NPORTS-1:0][DW-1:0] port_data;

    mwm_collide #(.AW(AW), .EXCL(EXCL)) u_collide (
        .en     ({wc_en, wb_en, wa_en}),
        .addr_a (wa_addr),
        .addr_b (wb_addr),
        .addr_c (wc_addr),
        .hit_ab (hit_ab),
        .hit_ac (hit_ac),
        .hit_bc (hit_bc),
        .act_a  (rnd_step[PORT_A]),
        .act_b  (rnd_step[PORT_B]),
        .we     (port_we)
    );

    generate
        for (genvar g = 0; g < NRAND; g++) begin : g_rnd
            localparam logic [DW-1:0] SEED_G = (g == 0) ? DW'(SEED_A) : DW'(SEED_B);
            mwm_lfsr #(.W(DW), .SEED(SEED_G), .TAPS(DW'(LFSR_TAPS))) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (rnd_step[g]),
                .word  (rnd_word[g])
            );
        end
    endgenerate

    assign port_addr[PORT_A] = wa_addr;
    assign port_addr[PORT_B] = wb_addr;
    assign port_addr[PORT_C] = wc_addr;
    assign port_data[PORT_A] = rnd_step[PORT_A] ? rnd_word[PORT_A] : wa_data;
    assign port_data[PORT_B] = rnd_step[PORT_B] ? rnd_word[PORT_B] : wb_data;
    assign port_data[PORT_C] = wc_data;

    mwm_store #(.DEPTH(DEPTH), .DW(DW), .NPORTS(NPORTS)) u_store (
        .clk   (clk),
        .we    (port_we),
        .waddr (port_addr),
        .wdata (port_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/mwm_resolver_chk.sv
`timescale 1ns/1ps
module mwm_resolver_chk #(
    parameter int         AW   = 5,
    parameter int         DW   = 32,
    parameter logic [2:0] EXCL = 3'b000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wa_en,
    input logic [AW-1:0] wa_addr,
    input logic          wb_en,
    input logic [AW-1:0] wb_addr,
    input logic [DW-1:0] wb_data,
    input logic          wc_en,
    input logic [AW-1:0] wc_addr,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic [1:0]    rnd_step,
    input logic [1:0][DW-1:0] rnd_word,
    input logic [2:0]    port_we
);
    AST_RND_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_step[0] |=> $stable(rnd_word[0])); // R8
    AST_RND_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_step[1] |=> $stable(rnd_word[1])); // R8
    AST_RND_A_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_step[0] |=> !$stable(rnd_word[0])); // R8
    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_word[0] != '0) && (rnd_word[1] != '0)); // R1
    AST_B_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && wa_addr == wb_addr && !EXCL[0]) |-> !port_we[1]); // R4
    AST_C_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_en && ((wa_en && wa_addr == wc_addr && !EXCL[1]) ||
                   (wb_en && wb_addr == wc_addr && !EXCL[2]))) |-> !port_we[2]); // R5
    AST_SOLO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wb_en && !wa_en && !wc_en) && rd_addr == $past(wb_addr))
        |-> rd_data == $past(wb_data)); // R2
endmodule

bind mwm_resolver mwm_resolver_chk #(.AW(AW), .DW(DW), .EXCL(EXCL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wa_en    (wa_en),
    .wa_addr  (wa_addr),
    .wb_en    (wb_en),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .wc_en    (wc_en),
    .wc_addr  (wc_addr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rnd_step (rnd_step),
    .rnd_word (rnd_word),
    .port_we  (port_we)
);

// File: tb/test_mwm_resolver.sv
`timescale 1ns/1ps
module test_mwm_resolver;
    localparam logic [31:0] SA = 32'hACE1_2468;
    localparam logic [31:0] SB = 32'h1357_BDF1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wa_en = 1'b0, wb_en = 1'b0, wc_en = 1'b0;
    logic [4:0]  wa_addr = '0, wb_addr = '0, wc_addr = '0, rd_addr = '0;
    logic [31:0] wa_data = '0, wb_data = '0, wc_data = '0;
    logic [31:0] rd_main, rd_excl;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mwm_resolver #(.EXCL(3'b000), .SEED_A(SA), .SEED_B(SB)) i_mwm_resolver (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .wc_en(wc_en), .wc_addr(wc_addr), .wc_data(wc_data),
        .rd_addr(rd_addr), .rd_data(rd_main));

    mwm_resolver #(.EXCL(3'b010), .SEED_A(SA), .SEED_B(SB)) i_mwm_resolver_excl (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .wc_en(wc_en), .wc_addr(wc_addr), .wc_data(wc_data),
        .rd_addr(rd_addr), .rd_data(rd_excl));

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] exp0;
        logic [31:0] exp1;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // Reference state, index 0 = no exclusive pairs, index 1 = first/third exclusive
    logic [31:0] mdl_mem [2][32];
    logic [31:0] mdl_ga [2];
    logic [31:0] mdl_gb [2];
    logic [2:0]  mdl_ex [2];

    function automatic logic [31:0] next_word(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
    endfunction

    task automatic model_step(input int k);
        logic ab, ac, bc;
        ab = wa_en && wb_en && (wa_addr == wb_addr) && !mdl_ex[k][0];
        ac = wa_en && wc_en && (wa_addr == wc_addr) && !mdl_ex[k][1];
        bc = wb_en && wc_en && (wb_addr == wc_addr) && !mdl_ex[k][2];
        if (wa_en) mdl_mem[k][wa_addr] = (ab || ac) ? mdl_ga[k] : wa_data;
        if (wb_en && !ab) mdl_mem[k][wb_addr] = bc ? mdl_gb[k] : wb_data;
        if (wc_en && !ac && !bc) mdl_mem[k][wc_addr] = wc_data;
        if (ab || ac) mdl_ga[k] = next_word(mdl_ga[k]);
        if (bc) mdl_gb[k] = next_word(mdl_gb[k]);
    endtask

    task automatic push_addr(input logic [4:0] a, input string tag);
        item_t it;
        it.addr = a;
        it.exp0 = mdl_mem[0][a];
        it.exp1 = mdl_mem[1][a];
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic apply(input logic ae, input logic [4:0] aa, input logic [31:0] ad,
                         input logic be, input logic [4:0] ba, input logic [31:0] bd,
                         input logic ce, input logic [4:0] ca, input logic [31:0] cd,
                         input string tag);
        @(negedge clk);
        wa_en = ae; wa_addr = aa; wa_data = ad;
        wb_en = be; wb_addr = ba; wb_data = bd;
        wc_en = ce; wc_addr = ca; wc_data = cd;
        @(posedge clk);
        model_step(0);
        model_step(1);
        #1;
        wa_en = 1'b0; wb_en = 1'b0; wc_en = 1'b0;
        if (ae) push_addr(aa, tag);
        if (be) push_addr(ba, tag);
        if (ce) push_addr(ca, tag);
        wait (sb_q.size() == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wa_en = 1'b0; wb_en = 1'b0; wc_en = 1'b0;
        end
    endtask

    // Monitor: pops expected items and compares the combinational read (R10)
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q[0];
            rd_addr = it.addr;
            #0.5;
            n_vec++;
            if (rd_main !== it.exp0) begin
                n_bad++;
                $display("FAIL %s main addr %0d: got %h expected %h", it.tag, it.addr, rd_main, it.exp0);
            end
            n_vec++;
            if (rd_excl !== it.exp1) begin
                n_bad++;
                $display("FAIL %s excl addr %0d: got %h expected %h", it.tag, it.addr, rd_excl, it.exp1);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        mdl_ex[0] = 3'b000;
        mdl_ex[1] = 3'b010;
        for (int k = 0; k < 2; k++) begin
            mdl_ga[k] = SA;
            mdl_gb[k] = SB;
            for (int a = 0; a < 32; a++) mdl_mem[k][a] = 'x;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: single uncontested writes
        apply(1, 5'd5, 32'h0000_A005, 0, 5'd0, 0, 0, 5'd0, 0, "R2");
        apply(0, 5'd0, 0, 1, 5'd6, 32'h0000_B006, 0, 5'd0, 0, "R2");
        apply(0, 5'd0, 0, 0, 5'd0, 0, 1, 5'd7, 32'h0000_C007, "R2");
        // R3: all enabled on distinct addresses; enabled vs disabled on same address
        apply(1, 5'd20, 32'hA020, 1, 5'd21, 32'hB021, 1, 5'd22, 32'hC022, "R3");
        apply(1, 5'd23, 32'hA023, 0, 5'd23, 32'hB023, 0, 5'd23, 32'hC023, "R3");
        // R1 / R4: first collision after reset stores SEED_A
        apply(1, 5'd9, 32'hA009, 1, 5'd9, 32'hB009, 0, 5'd0, 0, "R1 R4");
        // R5 / R9: first/third collision; exclusive instance keeps third's data
        apply(1, 5'd10, 32'hA010, 0, 5'd0, 0, 1, 5'd10, 32'hC010, "R5 R9");
        // R6: second/third collision stores SEED_B
        apply(0, 5'd0, 0, 1, 5'd11, 32'hB011, 1, 5'd11, 32'hC011, "R6");
        // R7: triple collision
        apply(1, 5'd12, 32'hA012, 1, 5'd12, 32'hB012, 1, 5'd12, 32'hC012, "R7");
        // R4 with third port elsewhere: third writes normally
        apply(1, 5'd13, 32'hA013, 1, 5'd13, 32'hB013, 1, 5'd14, 32'hC014, "R4 R3");
        // R8: idle cycles do not step generators
        idle(5);
        apply(1, 5'd15, 32'hA015, 1, 5'd15, 32'hB015, 0, 5'd0, 0, "R8 R9");
        apply(0, 5'd0, 0, 1, 5'd16, 32'hB016, 1, 5'd16, 32'hC016, "R8");
        // Random stream on four addresses
        for (int i = 0; i < 300; i++) begin
            apply($urandom_range(1, 0), 5'($urandom_range(3, 0)), $urandom,
                  $urandom_range(1, 0), 5'($urandom_range(3, 0)), $urandom,
                  $urandom_range(1, 0), 5'($urandom_range(3, 0)), $urandom,
                  "R10 R8 R9");
        end
        finish_run();
    end
endmodule